// File: doc/BRIEF.md
# Master Synchronous Serial Port

This block is a serial port that always acts as the bus master toward a single attached slave. It drives the shift clock (`sclk`), an active-low frame select (`cs_n`) and the outgoing data line (`mosi`), and it samples the returning data line (`miso`). A frame is 4 to 16 bits long and is sent most significant bit first. `sclk` idles low. Outgoing data changes on the falling edge of `sclk`, and incoming data is captured on the rising edge.

The host places outgoing words in a 16-entry transmit FIFO through 32-bit writes. Only the low 16 bits of each write are stored. Incoming frames collect in a 16-entry receive FIFO, which the host pops through 32-bit reads. Received values are right-justified and zero-extended.

The bit rate comes from a divider that produces one `sclk` period every `2*(div+1)` reference ticks, so the ratio runs from 2 to 512. The reference is either the system clock or the rising edges of a separate external clock input, which the block synchronises. While the port is enabled, transfers start on their own whenever words are waiting, and consecutive frames run back to back.

Top module: `ssp_master`

## Requirements
- R1: `sclk` is low and `mosi` is low whenever `cs_n` is high. After reset, `cs_n` is 1, `sclk` is 0, `busy` is 0, `overrun` is 0, and both FIFO levels are 0.
- R2: The frame length N equals `frame_bits` when that value is between 4 and 16. Values below 4 give N=4, and values above 16 give N=16.
- R3: Each frame sends bits [N-1:0] of the transmit entry most significant bit first on `mosi`, which changes on falling `sclk` edges. It captures N bits of `miso` on rising `sclk` edges. The stored word holds the first captured bit at bit N-1 and the last at bit 0, and `rx_rdata[31:N]` reads as 0.
- R4: A pulse on `tx_wr` stores `tx_wdata[15:0]` into the transmit FIFO, which holds 16 entries. A write while the FIFO is full is ignored and overwrites no stored entry.
- R5: `rx_rdata` shows the oldest received word, and a pulse on `rx_rd` removes it. A read while the receive FIFO is empty has no effect.
- R6: While a frame is in progress, one `sclk` period lasts `2*(div+1)` reference ticks.
- R7: When `ref_sel` is 0, the reference tick is every system clock. When `ref_sel` is 1, the tick is each rising edge of `ext_clk`. A new `ref_sel` value takes effect only while `enable` is 0 and no frame is in progress.
- R8: While `enable` is 1 and the transmit FIFO is not empty, frames start automatically and follow one another back to back, with `cs_n` held low across the whole run.
- R9: If a frame completes while the receive FIFO holds 16 words, the new word is dropped and `overrun` is set and stays set. A 1 on `ovr_clr` clears it, and a new overrun in the same cycle takes priority over the clear.
- R10: `busy` is 1 from the start of the first frame until the last bit of the final frame has been shifted. When `busy` falls, the transmit FIFO is empty or the port is disabled.
- R11: `tx_level` and `rx_level` report the number of entries held in each FIFO, from 0 to 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the internal reference |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows frames to start |
| ref_sel | input | 1 | Reference select: 0 = system clock, 1 = external clock |
| ext_clk | input | 1 | External reference clock |
| div | input | 8 | Divider setting; sclk period = 2*(div+1) ticks |
| frame_bits | input | 5 | Frame length in bits (clamped to 4..16) |
| tx_wr | input | 1 | Push one transmit word |
| tx_wdata | input | 32 | Host write word; bits [15:0] are stored |
| tx_level | output | 5 | Transmit FIFO occupancy |
| rx_rd | input | 1 | Pop one received word |
| rx_rdata | output | 32 | Oldest received word, zero-extended |
| rx_level | output | 5 | Receive FIFO occupancy |
| ovr_clr | input | 1 | Write-one-to-clear for `overrun` |
| overrun | output | 1 | Sticky receive overrun flag |
| busy | output | 1 | A frame is in progress |
| sclk | output | 1 | Serial shift clock |
| cs_n | output | 1 | Active-low frame select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Two conditions are hard to reach from the ports. The first is a frame that completes while the receive FIFO is already full. The bench fills it with sixteen unread frames and then sends two more. The second is a change of `ref_sel` while the port is enabled. The bench locks in the external reference while disabled, enables the port with nothing queued, flips the select, and then checks that the measured `sclk` period still follows the external clock. Random rounds vary the frame length, the divider and the batch size against a slave model that shifts out its own random words.

// File: rtl/ssp_master.sv
module ssp_master #(
  parameter int DW     = 16,
  parameter int DEPTH  = 16,
  parameter int DIV_W  = 8,
  parameter int HOST_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        enable,
  input  logic                        ref_sel,
  input  logic                        ext_clk,
  input  logic [DIV_W-1:0]            div,
  input  logic [$clog2(DW+1)-1:0]     frame_bits,
  input  logic                        tx_wr,
  input  logic [HOST_W-1:0]           tx_wdata,
  output logic [$clog2(DEPTH):0]      tx_level,
  input  logic                        rx_rd,
  output logic [HOST_W-1:0]           rx_rdata,
  output logic [$clog2(DEPTH):0]      rx_level,
  input  logic                        ovr_clr,
  output logic                        overrun,
  output logic                        busy,
  output logic                        sclk,
  output logic                        cs_n,
  output logic                        mosi,
  input  logic                        miso
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int BW = $clog2(DW + 1);

  logic [DW-1:0] txm [DEPTH];
  logic [DW-1:0] rxm [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  logic [2:0]       ext_s;
  logic             ref_q, active, sclk_r;
  logic [DIV_W-1:0] cnt;
  logic [BW-1:0]    bits_left, nbits;
  logic [DW-1:0]    tx_sh, rx_sh;

  wire tx_full  = tx_cnt == CW'(DEPTH);
  wire tx_empty = tx_cnt == '0;
  wire rx_full  = rx_cnt == CW'(DEPTH);
  wire rx_empty = rx_cnt == '0;

  wire ext_rise = ext_s[1] & ~ext_s[2];
  wire tick     = ref_q ? ext_rise : 1'b1;
  wire half     = active && tick && cnt == div;
  wire done     = half && sclk_r && bits_left == '0;
  wire load     = enable && !tx_empty && (!active || done);

  wire tx_push  = tx_wr && !tx_full;
  wire rx_push  = done && !rx_full;
  wire rx_pop   = rx_rd && !rx_empty;

  always_comb begin
    if (frame_bits < BW'(4))       nbits = BW'(4);
    else if (frame_bits > BW'(DW)) nbits = BW'(DW);
    else                           nbits = frame_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_s     <= '0;
      ref_q     <= 1'b0;
      active    <= 1'b0;
      sclk_r    <= 1'b0;
      cnt       <= '0;
      bits_left <= '0;
      tx_sh     <= '0;
      rx_sh     <= '0;
    end else begin
      ext_s <= {ext_s[1:0], ext_clk};
      if (!enable && !active) ref_q <= ref_sel;
      if (active && tick) cnt <= (cnt == div) ? '0 : cnt + 1'b1;
      if (load) begin
        active    <= 1'b1;
        sclk_r    <= 1'b0;
        cnt       <= '0;
        bits_left <= nbits;
        tx_sh     <= txm[tx_rp] << (DW - int'(nbits));
        rx_sh     <= '0;
      end else if (half) begin
        if (!sclk_r) begin
          sclk_r    <= 1'b1;
          rx_sh     <= {rx_sh[DW-2:0], miso};
          bits_left <= bits_left - 1'b1;
        end else begin
          sclk_r <= 1'b0;
          if (bits_left == '0) active <= 1'b0;
          else                 tx_sh  <= tx_sh << 1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) txm[tx_wp] <= tx_wdata[DW-1:0];
    if (rx_push) rxm[rx_wp] <= rx_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp   <= '0;
      tx_rp   <= '0;
      tx_cnt  <= '0;
      rx_wp   <= '0;
      rx_rp   <= '0;
      rx_cnt  <= '0;
      overrun <= 1'b0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (load)    tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(load);
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
      if (done && rx_full) overrun <= 1'b1;
      else if (ovr_clr)    overrun <= 1'b0;
    end
  end

  assign tx_level = tx_cnt;
  assign rx_level = rx_cnt;
  assign rx_rdata = HOST_W'(rxm[rx_rp]);
  assign busy     = active;
  assign sclk     = sclk_r;
  assign cs_n     = !active;
  assign mosi     = active & tx_sh[DW-1];

  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!sclk && !mosi));
  p_tx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= CW'(DEPTH));
  p_rx_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= CW'(DEPTH));
  p_sclk_moves_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk) |-> $past(busy));
  p_ref_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(enable) |-> $stable(ref_q));
  p_full_no_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == CW'(DEPTH) && !rx_rd) |=> rx_level == CW'(DEPTH));
  p_ovr_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rx_level) == CW'(DEPTH));
  p_busy_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tx_level == '0 || !enable));
endmodule

// File: tb/ssp_master_test.sv
module ssp_master_test;
  logic        clk = 0, rst_n = 0;
  logic        enable = 0, ref_sel = 0, ext_clk = 0;
  logic [7:0]  div = 0;
  logic [4:0]  frame_bits = 5'd8;
  logic        tx_wr = 0, rx_rd = 0, ovr_clr = 0;
  logic [31:0] tx_wdata = 0;
  logic [4:0]  tx_level, rx_level;
  logic [31:0] rx_rdata;
  logic        overrun, busy, sclk, cs_n, mosi, miso;

  ssp_master uut (.clk(clk), .rst_n(rst_n), .enable(enable), .ref_sel(ref_sel),
    .ext_clk(ext_clk), .div(div), .frame_bits(frame_bits), .tx_wr(tx_wr),
    .tx_wdata(tx_wdata), .tx_level(tx_level), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
    .rx_level(rx_level), .ovr_clr(ovr_clr), .overrun(overrun), .busy(busy),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  always #5 clk = ~clk;
  always #30 ext_clk = ~ext_clk;

  int nvec = 0, nfail = 0;
  int cur_n = 8, sl_idx = 0, cs_rises = 0;
  int cyc = 0, last_rise = 0, last_per = 0;
  logic [15:0] sl_word = 16'h0, mo_acc = 16'h0;
  logic [15:0] cap_q[$], sl_q[$], exp_q[$];

  function automatic logic [15:0] mask(int n);
    return 16'((32'd1 << n) - 1);
  endfunction

  function automatic int clampn(int fb);
    return fb < 4 ? 4 : (fb > 16 ? 16 : fb);
  endfunction

  assign miso = (sl_idx < cur_n) ? sl_word[4'(cur_n - 1 - sl_idx)] : 1'b0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge cs_n) cs_rises++;
  always @(posedge sclk) begin
    last_per  = cyc - last_rise;
    last_rise = cyc;
    mo_acc = {mo_acc[14:0], mosi};
    sl_idx++;
    if (sl_idx == cur_n) begin
      cap_q.push_back(mo_acc & mask(cur_n));
      sl_q.push_back(sl_word & mask(cur_n));
      mo_acc  = 16'h0;
      sl_idx  = 0;
      sl_word = 16'($urandom);
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(logic [31:0] w);
    @(negedge clk); tx_wr = 1; tx_wdata = w;
    @(negedge clk); tx_wr = 0;
  endtask

  task automatic pop(output logic [31:0] v);
    @(negedge clk); v = rx_rdata; rx_rd = 1;
    @(negedge clk); rx_rd = 0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 60000; i++) begin
      if (!busy && tx_level == 0) break;
      @(negedge clk);
    end
  endtask

  task automatic clear_q();
    cap_q.delete(); sl_q.delete(); exp_q.delete();
  endtask

  task automatic round(int fb, int d, int k);
    logic [31:0] w, v;
    int rises0;
    frame_bits = 5'(fb); cur_n = clampn(fb); div = 8'(d);
    clear_q();
    for (int i = 0; i < k; i++) begin
      w = $urandom;
      exp_q.push_back(w[15:0] & mask(cur_n));
      push(w);
    end
    chk("R11 tx_level after pushes", 32'(tx_level), 32'(k));
    rises0 = cs_rises;
    @(negedge clk); enable = 1;
    repeat (4) @(negedge clk);
    chk("R10 busy during frames", 32'(busy), 1);
    chk("R1 cs_n low in frame", 32'(cs_n), 0);
    wait_idle();
    @(negedge clk); enable = 0;
    chk("R10 busy low after last frame", 32'(busy), 0);
    chk("R8 one cs_n rise per run", 32'(cs_rises - rises0), 1);
    chk("R8 frame count", 32'(cap_q.size()), 32'(k));
    for (int i = 0; i < k && i < cap_q.size(); i++)
      chk("R3 R2 mosi frame", 32'(cap_q[i]), 32'(exp_q[i]));
    chk("R11 rx_level", 32'(rx_level), 32'(k));
    for (int i = 0; i < k; i++) begin
      pop(v);
      chk("R3 R5 rx word zero-extended", v, (i < sl_q.size()) ? 32'(sl_q[i]) : 32'hx);
    end
    chk("R5 rx drained", 32'(rx_level), 0);
  endtask

  initial begin
    #(200000 * 10);
    nfail++;
    $display("FAIL watchdog expired (R10 run did not finish)");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    sl_word = 16'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset cs_n", 32'(cs_n), 1);
    chk("R1 reset sclk", 32'(sclk), 0);
    chk("R1 reset busy", 32'(busy), 0);
    chk("R1 reset overrun", 32'(overrun), 0);
    chk("R11 reset levels", {27'd0, tx_level} | {27'd0, rx_level}, 0);

    // R5 read on empty is ignored
    pop(v);
    chk("R5 empty read ignored", 32'(rx_level), 0);

    for (int r = 0; r < 8; r++)
      round(4 + int'($urandom % 13), int'($urandom % 4), 1 + int'($urandom % 8));
    round(2, 0, 3);    // R2 clamp low
    round(20, 1, 3);   // R2 clamp high
    round(4, 0, 16);   // R2 minimum
    round(16, 2, 2);   // R2 maximum

    // R6 divider at the largest ratio
    round(4, 255, 1);
    chk("R6 sclk period div=255", 32'(last_per), 512);
    round(5, 0, 1);
    chk("R6 sclk period div=0", 32'(last_per), 2);

    // R7 external reference, chosen while disabled
    ref_sel = 1;
    round(4, 1, 1);
    chk("R7 external reference period", 32'(last_per), 24);
    // R7 select flipped while enabled is ignored
    @(negedge clk); enable = 1;
    @(negedge clk); ref_sel = 0;
    frame_bits = 5'd6; cur_n = 6; clear_q();
    push(32'h0000_002A);
    wait_idle();
    chk("R7 select held while enabled", 32'(last_per), 24);
    @(negedge clk); enable = 0;
    pop(v);
    repeat (2) @(negedge clk);
    round(4, 1, 1);
    chk("R7 internal reference restored", 32'(last_per), 4);

    // R9 overrun
    frame_bits = 5'd8; cur_n = 8; div = 0; clear_q();
    for (int i = 0; i < 16; i++) push($urandom);
    @(negedge clk); enable = 1;
    wait_idle();
    chk("R9 full without overrun", 32'(overrun), 0);
    chk("R11 rx full", 32'(rx_level), 16);
    push($urandom); push($urandom);
    wait_idle();
    chk("R9 overrun set", 32'(overrun), 1);
    chk("R9 word dropped", 32'(rx_level), 16);
    @(negedge clk); enable = 0;
    repeat (5) @(negedge clk);
    chk("R9 overrun sticky", 32'(overrun), 1);
    @(negedge clk); ovr_clr = 1;
    @(negedge clk); ovr_clr = 0;
    chk("R9 overrun cleared", 32'(overrun), 0);
    for (int i = 0; i < 16; i++) begin
      pop(v);
      chk("R9 kept words", v, 32'(sl_q[i]));
    end

    // R4 write to full transmit FIFO ignored
    clear_q();
    for (int i = 0; i < 17; i++) begin
      v = {16'hA5A5, 16'(i * 16'h0101 + 16'h0F)};
      if (i < 16) exp_q.push_back(v[15:0] & mask(8));
      push(v);
    end
    chk("R4 tx full", 32'(tx_level), 16);
    @(negedge clk); enable = 1;
    wait_idle();
    @(negedge clk); enable = 0;
    chk("R4 only 16 frames", 32'(cap_q.size()), 16);
    for (int i = 0; i < 16 && i < cap_q.size(); i++)
      chk("R4 stored low half", 32'(cap_q[i]), 32'(exp_q[i]));
    for (int i = 0; i < 16; i++) pop(v);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule